// File: doc/BRIEF.md
# Bank-Selectable Output Range Limiter

This block sits at the tail of a filter datapath and clamps each output sample to a programmable signed window. A bank of sixteen 32-bit range words holds a window each: a lower bound and an upper bound. A 4-bit select input chooses the window for the sample in the current cycle. Because the select can change from one clock to the next, interleaved channels that share the datapath can each be held to their own range.

A single enable input switches the clamp on or off. When it is off, samples go through unchanged. The range words are loaded through a simple write port. The result is registered, so it appears one clock after the sample, and an output valid flag follows the input valid.

Software must load every window with its upper bound above its lower bound. When the clamp is on, a sample that lies between the two bounds, or equal to either of them, is not altered.

Top module: `range_clamp`

## Requirements
- R1: After reset `out_valid` is 0, `out_sample` is 0, and every range word holds lower bound -32768 and upper bound 32767, so samples pass unchanged through any bank.
- R2: A cycle with `lim_we` high stores `lim_wdata` into range word `lim_waddr`. The lower bound is bits 15:0 and the upper bound is bits 31:16, both 16-bit two's complement.
- R3: `bank_sel` value n applies range word n to the sample in the same cycle. A different value may be used in every cycle.
- R4: With the clamp enabled, a sample below the selected lower bound produces the lower bound.
- R5: With the clamp enabled, a sample above the selected upper bound produces the upper bound.
- R6: With the clamp enabled, a sample within the selected bounds, including a sample equal to either bound, is output unchanged. All comparisons are signed.
- R7: With `clamp_en` low, the sample is output unchanged whatever the selected bounds are.
- R8: The result of a sample presented with `in_valid` high appears on `out_sample` one clock later, and `out_valid` equals `in_valid` delayed by one clock.
- R9: While `in_valid` is low, `out_sample` keeps its previous value.
- R10: A write to the range word that is selected in the same cycle does not affect that cycle's sample. The new bounds apply from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lim_we | input | 1 | Range word write strobe |
| lim_waddr | input | 4 | Index of the range word to write |
| lim_wdata | input | 32 | Upper bound in bits 31:16, lower bound in bits 15:0 |
| clamp_en | input | 1 | 1 = clamp the sample, 0 = pass it unchanged |
| bank_sel | input | 4 | Index of the range word applied to the current sample |
| in_valid | input | 1 | Sample qualifier |
| in_sample | input | 16 | Signed input sample |
| out_valid | output | 1 | Delayed `in_valid` |
| out_sample | output | 16 | Registered signed result |

## Verification
Directed samples are placed one below, exactly on, and one above each bound of a loaded window. These cases catch off-by-one and strict-versus-inclusive comparison errors, and a negative lower bound exposes any unsigned compare.

Alternating the select between two banks on successive cycles, with the same sample value, shows whether the applied window follows the select in that very cycle. A write to the selected bank in the same cycle as a sample separates the old bounds from the new ones.

Long random runs mix enable, select, valid gaps and rewrites against a bench model of the bank. They cover bypass, hold behaviour and every bank.

// File: rtl/range_clamp.sv
module range_clamp #(
  parameter int NUM_BANKS = 16,
  parameter int DW        = 16,
  localparam int AW       = $clog2(NUM_BANKS),
  localparam int BW       = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lim_we,
  input  logic [AW-1:0]        lim_waddr,
  input  logic [BW-1:0]        lim_wdata,
  input  logic                 clamp_en,
  input  logic [AW-1:0]        bank_sel,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_sample
);

  localparam logic [BW-1:0] OPEN_RANGE = {1'b0, {(DW-1){1'b1}}, 1'b1, {(DW-1){1'b0}}};

  logic [BW-1:0]        bank_q [NUM_BANKS];
  logic [BW-1:0]        sel_word;
  logic signed [DW-1:0] sel_lo, sel_hi, clamped, result;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BANKS; i++) bank_q[i] <= OPEN_RANGE;
    end else if (lim_we) begin
      bank_q[lim_waddr] <= lim_wdata;
    end
  end

  assign sel_word = bank_q[bank_sel];
  assign sel_lo   = sel_word[DW-1:0];
  assign sel_hi   = sel_word[BW-1:DW];

  assign clamped = (in_sample < sel_lo) ? sel_lo :
                   (in_sample > sel_hi) ? sel_hi : in_sample;
  assign result  = clamp_en ? clamped : in_sample;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_sample <= result;
    end
  end

endmodule

module range_clamp_chk #(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clamp_en,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_sample,
  input logic signed [DW-1:0] sel_lo,
  input logic signed [DW-1:0] sel_hi,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_sample
);

  p_valid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_sample));

  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !clamp_en |=> out_sample == $past(in_sample));

  p_in_window_r4_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && clamp_en && (sel_lo <= sel_hi) |=>
      (out_sample >= $past(sel_lo)) && (out_sample <= $past(sel_hi)));

  p_pass_inside_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && clamp_en && (in_sample >= sel_lo) && (in_sample <= sel_hi) |=>
      out_sample == $past(in_sample));

endmodule

bind range_clamp range_clamp_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clamp_en(clamp_en), .in_valid(in_valid),
  .in_sample(in_sample), .sel_lo(sel_lo), .sel_hi(sel_hi),
  .out_valid(out_valid), .out_sample(out_sample)
);

// File: tb/tb_range_clamp.sv
`timescale 1ns/1ps
module tb_range_clamp;

  localparam int CYC = 20;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               lim_we = 1'b0;
  logic [3:0]         lim_waddr = '0;
  logic [31:0]        lim_wdata = '0;
  logic               clamp_en = 1'b0;
  logic [3:0]         bank_sel = '0;
  logic               in_valid = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic               out_valid;
  logic signed [15:0] out_sample;

  int checks = 0;
  int errors = 0;
  logic [31:0]        mdl [16];
  logic signed [15:0] exp_out = '0;

  always #(CYC/2) clk = ~clk;

  range_clamp dut (
    .clk(clk), .rst_n(rst_n), .lim_we(lim_we), .lim_waddr(lim_waddr),
    .lim_wdata(lim_wdata), .clamp_en(clamp_en), .bank_sel(bank_sel),
    .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  function automatic logic signed [15:0] model_out(logic [31:0] w, logic en, logic signed [15:0] s);
    logic signed [15:0] lo, hi;
    lo = w[15:0];
    hi = w[31:16];
    if (!en) return s;
    if (s < lo) return lo;
    if (s > hi) return hi;
    return s;
  endfunction

  function automatic string auto_tag(logic [31:0] w, logic en, logic v, logic signed [15:0] s);
    logic signed [15:0] lo, hi;
    lo = w[15:0];
    hi = w[31:16];
    if (!v) return "R9";
    if (!en) return "R7";
    if (s < lo) return "R4";
    if (s > hi) return "R5";
    return "R6";
  endfunction

  task automatic check(string tag, logic av, logic signed [15:0] as, logic ev, logic signed [15:0] es);
    checks++;
    if (av !== ev || as !== es) begin
      errors++;
      $display("FAIL %s: valid=%0b sample=%0d, expected valid=%0b sample=%0d", tag, av, as, ev, es);
    end
  endtask

  task automatic cyc(logic v, logic signed [15:0] s, logic [3:0] sel, logic en,
                     logic we, logic [3:0] wa, logic [31:0] wd, string tag);
    @(negedge clk);
    in_valid = v; in_sample = s; bank_sel = sel; clamp_en = en;
    lim_we = we; lim_waddr = wa; lim_wdata = wd;
    if (tag == "") tag = auto_tag(mdl[sel], en, v, s);
    if (v) exp_out = model_out(mdl[sel], en, s);
    @(posedge clk);
    #1;
    check(tag, out_valid, out_sample, v, exp_out);
    if (we) mdl[wa] = wd;
  endtask

  task automatic wr(logic [3:0] a, logic signed [15:0] lo, logic signed [15:0] hi);
    cyc(1'b0, 16'sd0, 4'd0, 1'b1, 1'b1, a, {hi, lo}, "R2");
  endtask

  initial begin
    #(CYC * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) mdl[i] = 32'h7FFF_8000;
    #(CYC * 3 + 3);
    check("R1", out_valid, out_sample, 1'b0, 16'sd0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", out_valid, out_sample, 1'b0, 16'sd0);

    cyc(1, -16'sd32768, 4'd0,  1, 0, 0, 0, "R1");
    cyc(1,  16'sd32767, 4'd15, 1, 0, 0, 0, "R1");
    cyc(1, -16'sd5,     4'd7,  1, 0, 0, 0, "R1");

    wr(4'd3, -16'sd100, 16'sd200);
    cyc(1, -16'sd101, 4'd3, 1, 0, 0, 0, "R4");
    cyc(1, -16'sd100, 4'd3, 1, 0, 0, 0, "R6");
    cyc(1,  16'sd201, 4'd3, 1, 0, 0, 0, "R5");
    cyc(1,  16'sd200, 4'd3, 1, 0, 0, 0, "R6");
    cyc(1,  16'sd50,  4'd3, 1, 0, 0, 0, "R6");
    cyc(1, -16'sd30000, 4'd3, 1, 0, 0, 0, "R4");
    cyc(1,  16'sd5000, 4'd3, 0, 0, 0, 0, "R7");

    wr(4'd5, 16'sd0, 16'sd10);
    cyc(1, 16'sd150, 4'd3, 1, 0, 0, 0, "R3");
    cyc(1, 16'sd150, 4'd5, 1, 0, 0, 0, "R3");
    cyc(1, 16'sd150, 4'd3, 1, 0, 0, 0, "R3");
    cyc(1, 16'sd150, 4'd5, 1, 0, 0, 0, "R3");

    cyc(1, 16'sd150, 4'd3, 1, 1, 4'd3, {16'sd1, 16'sd0}, "R10");
    cyc(1, 16'sd150, 4'd3, 1, 0, 0, 0, "R10");

    cyc(0, 16'sd9999, 4'd5, 1, 0, 0, 0, "R9");
    cyc(0, -16'sd9999, 4'd0, 0, 0, 0, 0, "R8");
    cyc(1, 16'sd7, 4'd5, 1, 0, 0, 0, "R8");

    for (int n = 0; n < 4000; n++) begin
      logic we;
      logic signed [15:0] a, b;
      we = ($urandom % 8) == 0;
      a = 16'($urandom);
      b = 16'($urandom);
      if (a == b) b = a ^ 16'sd1;
      if (a > b) begin logic signed [15:0] t; t = a; a = b; b = t; end
      if (($urandom % 4) == 0) begin
        a = 16'($signed(16'($urandom % 512)) - 16'sd256);
        b = a + 16'sd100;
      end
      cyc(($urandom % 5) != 0, 16'($urandom), 4'($urandom), ($urandom % 6) != 0,
          we, 4'($urandom), {b, a}, "");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule